// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns one parallel data word into an asynchronous serial frame on a single output line that rests high between frames. A frame opens with one low start bit, carries the data least-significant bit first, may carry a parity bit, and closes with one or two high stop bits. The data length (5 to 9 bits), the parity mode (none, even, odd) and the stop-bit count are chosen per word through configuration inputs.

Every bit is held for a fixed number of system clock cycles set by a divisor input. The word, its format and the divisor are captured together when a valid/ready handshake completes. From then on the frame runs on its own, and a busy flag is raised. A new word is taken only once the last stop bit of the previous frame has fully elapsed.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is 1, busy is 0 and in_ready is 1.
- R2: A word is accepted on a clock edge where in_valid and in_ready are both 1. From that edge the line drives one start bit of value 0 for one bit period, and busy is 1.
- R3: The data bits follow the start bit, least-significant bit first. Their count is cfg_len, with values below 5 treated as 5 and values above 9 treated as 9.
- R4: cfg_par selects the parity: 2'b00 and 2'b11 mean no parity bit, 2'b01 means even and 2'b10 means odd. Under even parity the bit is 1 when the sent data bits hold an odd number of ones, and odd parity gives its inverse. When present, the parity bit comes right after the last data bit.
- R5: The frame ends with one stop bit at 1 when cfg_two_stop is 0, or two stop bits at 1 when it is 1.
- R6: Each bit lasts P clock cycles, where P is div_in, or 1 when div_in is 0. Busy stays high for exactly (2 + length + parity + extra stop) × P cycles, so 8 data bits, no parity and one stop bit give 10 bit periods.
- R7: in_ready is the inverse of busy. A word offered while busy is not taken and does not change the frame in progress.
- R8: Data, format and divisor are captured at acceptance. Changing these inputs during a frame has no effect on that frame.
- R9: Whenever busy is 0, the line output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_in | input | DIV_W | Clock cycles per bit (0 treated as 1) |
| cfg_len | input | LEN_W | Data length, clamped to MIN_DATA..MAX_DATA |
| cfg_par | input | 2 | Parity mode: 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| in_data | input | MAX_DATA | Word to send, bit 0 sent first |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted this cycle |
| tx | output | 1 | Serial line, high when idle |
| busy | output | 1 | Frame in progress |

## Verification
The bench goes after these corner cases:
- Lengths outside the legal range. A missing clamp would send too few or too many bits and shift the stop bits.
- The mode codes 11 and 10. Treating 11 as a parity mode would insert a stray bit, and an inverted parity polarity shows up on the byte with five ones.
- A divisor of 0 and a divisor of 1. An off-by-one in the bit counter stretches every bit or makes the frame stall.
- Inputs changed and a second word offered in the middle of a frame. A design that reads live inputs would corrupt the remaining bits or accept the word early.
- Two stop bits and back-to-back words. An early release of busy would cut the second stop bit short.

// File: rtl/sftx_pkg.sv
package sftx_pkg;
   typedef enum logic [1:0] {
      PAR_OFF  = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_OFF2 = 2'd3
   } par_mode_e;
endpackage

// File: rtl/sftx_baud.sv
module sftx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             run,
   input  logic [DIV_W-1:0] period,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= period - DIV_W'(1);
      else if (run)
         cnt <= (cnt == '0) ? period - DIV_W'(1) : cnt - DIV_W'(1);
   end

   assign tick = run && !load && (cnt == '0);
endmodule

// File: rtl/sftx_parity.sv
module sftx_parity #(
   parameter int MAX_DATA = 9,
   parameter int LEN_W    = 4
) (
   input  logic [MAX_DATA-1:0] data,
   input  logic [LEN_W-1:0]    len,
   output logic                odd_ones
);
   logic [MAX_DATA-1:0] keep;

   for (genvar i = 0; i < MAX_DATA; i++) begin : g_mask
      assign keep[i] = data[i] & (LEN_W'(i) < len);
   end

   assign odd_ones = ^keep;
endmodule

// File: rtl/sftx_framer.sv
module sftx_framer
   import sftx_pkg::*;
#(
   parameter int MAX_DATA = 9,
   parameter int LEN_W    = 4,
   parameter int FRAME_W  = 13,
   parameter int CNT_W    = 4
) (
   input  logic [MAX_DATA-1:0] data,
   input  logic [LEN_W-1:0]    len,
   input  logic [1:0]          par_mode,
   input  logic                two_stop,
   input  logic                odd_ones,
   output logic [FRAME_W-1:0]  frame,
   output logic [CNT_W-1:0]    nbits
);
   logic par_on;
   logic par_bit;

   assign par_on  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
   assign par_bit = odd_ones ^ (par_mode == PAR_ODD);

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (i < int'(len)) frame[i+1] = data[i];
      end
      if (par_on) frame[int'(len)+1] = par_bit;
      nbits = CNT_W'(2 + int'(len) + int'(par_on) + int'(two_stop));
   end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import sftx_pkg::*;
#(
   parameter  int DIV_W    = 16,
   parameter  int MIN_DATA = 5,
   parameter  int MAX_DATA = 9,
   localparam int LEN_W    = $clog2(MAX_DATA + 1)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [DIV_W-1:0]    div_in,
   input  logic [LEN_W-1:0]    cfg_len,
   input  logic [1:0]          cfg_par,
   input  logic                cfg_two_stop,
   input  logic [MAX_DATA-1:0] in_data,
   input  logic                in_valid,
   output logic                in_ready,
   output logic                tx,
   output logic                busy
);
   localparam int FRAME_W = MAX_DATA + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (MIN_DATA < 1) begin : g_bad_min
      $error("MIN_DATA must be at least 1");
   end
   if (MAX_DATA < MIN_DATA) begin : g_bad_range
      $error("MAX_DATA must not be below MIN_DATA");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic                busy_q;
   logic                tx_q;
   logic [FRAME_W-2:0]  shreg;
   logic [CNT_W-1:0]    left;
   logic [DIV_W-1:0]    per_q;
   logic [DIV_W-1:0]    div_eff;
   logic [DIV_W-1:0]    per_mux;
   logic [LEN_W-1:0]    len_eff;
   logic                accept;
   logic                tick;
   logic                odd_ones;
   logic [FRAME_W-1:0]  frame;
   logic [CNT_W-1:0]    nbits;

   assign accept   = in_valid && !busy_q;
   assign in_ready = !busy_q;
   assign busy     = busy_q;
   assign tx       = tx_q;

   assign div_eff = (div_in == '0) ? DIV_W'(1) : div_in;
   assign per_mux = accept ? div_eff : per_q;

   always_comb begin
      if (int'(cfg_len) < MIN_DATA)      len_eff = LEN_W'(MIN_DATA);
      else if (int'(cfg_len) > MAX_DATA) len_eff = LEN_W'(MAX_DATA);
      else                               len_eff = cfg_len;
   end

   sftx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst(rst), .load(accept), .run(busy_q),
      .period(per_mux), .tick(tick)
   );

   sftx_parity #(.MAX_DATA(MAX_DATA), .LEN_W(LEN_W)) u_par (
      .data(in_data), .len(len_eff), .odd_ones(odd_ones)
   );

   sftx_framer #(.MAX_DATA(MAX_DATA), .LEN_W(LEN_W), .FRAME_W(FRAME_W),
                 .CNT_W(CNT_W)) u_frm (
      .data(in_data), .len(len_eff), .par_mode(cfg_par),
      .two_stop(cfg_two_stop), .odd_ones(odd_ones),
      .frame(frame), .nbits(nbits)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         tx_q   <= 1'b1;
         shreg  <= '1;
         left   <= '0;
         per_q  <= DIV_W'(1);
      end else if (accept) begin
         busy_q <= 1'b1;
         tx_q   <= frame[0];
         shreg  <= frame[FRAME_W-1:1];
         left   <= nbits;
         per_q  <= div_eff;
      end else if (tick) begin
         if (left == CNT_W'(1)) begin
            busy_q <= 1'b0;
            tx_q   <= 1'b1;
            shreg  <= '1;
            left   <= '0;
         end else begin
            tx_q  <= shreg[0];
            shreg <= {1'b1, shreg[FRAME_W-2:1]};
            left  <= left - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/sftx_checker.sv
module sftx_checker #(
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             busy,
   input logic             tx,
   input logic             tick,
   input logic [DIV_W-1:0] per_q
);
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      !busy |-> tx); // R9
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> busy); // R7
   AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !tx); // R2
   AST_LAST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(tx)); // R5
   AST_BIT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
      ($past(busy) && busy && !$stable(tx)) |-> $past(tick)); // R6
   AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(per_q)); // R8
endmodule

bind serial_frame_tx sftx_checker #(.DIV_W(DIV_W)) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
   .busy(busy), .tx(tx), .tick(tick), .per_q(per_q)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
   localparam int DIV_W = 16;
   localparam int MAXD  = 9;
   localparam int LEN_W = $clog2(MAXD + 1);

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [DIV_W-1:0] div_in = '0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic [1:0]       cfg_par = '0;
   logic             cfg_two_stop = 1'b0;
   logic [MAXD-1:0]  in_data = '0;
   logic             in_valid = 1'b0;
   logic             in_ready, tx, busy;

   always #10 clk = ~clk;

   serial_frame_tx #(.DIV_W(DIV_W), .MIN_DATA(5), .MAX_DATA(MAXD)) u0 (
      .clk(clk), .rst(rst), .div_in(div_in), .cfg_len(cfg_len),
      .cfg_par(cfg_par), .cfg_two_stop(cfg_two_stop), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .tx(tx), .busy(busy)
   );

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   bit    ended = 0;
   string ctx = "";

   bit    bitq[$];
   string tagq[$];
   int    lenq[$];
   bit    exp_busy = 0;
   bit    acc_flag = 0;
   int    run_len = 0;
   logic [MAXD-1:0] m_data;
   int    m_len, m_div;
   logic [1:0] m_par;
   bit    m_two;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s %s: actual=%0d expected=%0d at cycle %0d",
                  tag, ctx, what, act, exp, cyc);
      end
   endtask

   task automatic push_bit(input bit b, input string tag, input int p);
      for (int k = 0; k < p; k++) begin
         bitq.push_back(b);
         tagq.push_back(tag);
      end
   endtask

   task automatic build_frame();
      int  p, n, ones;
      bit  pon;
      p = (m_div == 0) ? 1 : m_div;
      n = (m_len < 5) ? 5 : (m_len > 9) ? 9 : m_len;
      pon = (m_par == 2'd1) || (m_par == 2'd2);
      ones = 0;
      push_bit(1'b0, "R2", p);
      for (int i = 0; i < n; i++) begin
         push_bit(m_data[i], "R3", p);
         ones += int'(m_data[i]);
      end
      if (pon) push_bit((ones % 2 == 1) ^ (m_par == 2'd2), "R4", p);
      push_bit(1'b1, "R5", p);
      if (m_two) push_bit(1'b1, "R5", p);
      lenq.push_back((2 + n + int'(pon) + int'(m_two)) * p);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         bitq.delete(); tagq.delete(); lenq.delete();
         exp_busy = 0; acc_flag = 0; run_len = 0;
      end else if (in_valid && !exp_busy) begin
         m_data = in_data; m_len = int'(cfg_len); m_div = int'(div_in);
         m_par = cfg_par; m_two = cfg_two_stop;
         acc_flag = 1;
      end
   end

   always @(negedge clk) begin
      if (!rst && !ended) begin
         bit    etx;
         string tg;
         if (acc_flag) begin
            build_frame();
            acc_flag = 0;
         end
         exp_busy = (bitq.size() > 0);
         etx = exp_busy ? bitq[0] : 1'b1;
         tg  = exp_busy ? tagq[0] : "R9";
         chk(tx === etx, tg, "line", int'(tx), int'(etx));
         chk(busy === exp_busy, "R6", "busy", int'(busy), int'(exp_busy));
         chk(in_ready === !exp_busy, "R7", "in_ready", int'(in_ready),
             int'(!exp_busy));
         if (exp_busy) begin
            void'(bitq.pop_front());
            void'(tagq.pop_front());
         end
         if (busy === 1'b1) run_len++;
         else if (run_len > 0) begin
            if (lenq.size() > 0)
               chk(run_len == lenq[0], "R6", "frame cycles", run_len, lenq[0]);
            if (lenq.size() > 0) void'(lenq.pop_front());
            run_len = 0;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == 150000 && !ended) begin
         ended = 1;
         checks++; errors++;
         $display("FAIL R6 watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic send(input logic [MAXD-1:0] d, input int len,
                       input logic [1:0] par, input bit two, input int dv);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_data = d; cfg_len = LEN_W'(len); cfg_par = par;
      cfg_two_stop = two; div_in = DIV_W'(dv); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      in_data = ~d; cfg_len = LEN_W'(6); cfg_par = 2'd2;
      cfg_two_stop = ~two; div_in = DIV_W'(dv + 2);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(tx === 1'b1, "R1", "reset line", int'(tx), 1);
      chk(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
      chk(in_ready === 1'b1, "R1", "reset ready", int'(in_ready), 1);

      ctx = "8N1";      send(9'h04F, 8, 2'd0, 0, 4); wait_idle();
      ctx = "even";     send(9'h05D, 8, 2'd1, 0, 3); wait_idle();
      ctx = "odd";      send(9'h05D, 8, 2'd2, 0, 3); wait_idle();
      ctx = "len5 2stop"; send(9'h015, 5, 2'd0, 1, 2); wait_idle();
      ctx = "len9";     send(9'h1A5, 9, 2'd1, 1, 1); wait_idle();
      ctx = "len low";  send(9'h10F, 3, 2'd2, 0, 2); wait_idle();
      ctx = "len high mode3 div0"; send(9'h1FF, 12, 2'd3, 0, 0); wait_idle();

      ctx = "R8 disturbed";
      send(9'h033, 7, 2'd1, 1, 5);
      in_valid = 1'b1; in_data = 9'h1CC; cfg_len = LEN_W'(9);
      cfg_par = 2'd0; cfg_two_stop = 1'b0; div_in = DIV_W'(1);
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      wait_idle();

      ctx = "back to back";
      send(9'h0A5, 8, 2'd1, 1, 2);
      send(9'h05A, 6, 2'd2, 0, 1);
      wait_idle();

      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule